// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block multiplies two unsigned WIDTH-bit operands over several clock cycles, using one adder and no array of partial products. A start pulse loads the multiplicand into a holding register and the multiplier into the low half of a double-width working register whose high half (the accumulator) and a one-bit carry flop are cleared. On each following clock the block looks at the lowest bit of the low half. When that bit is one it adds the multiplicand into the accumulator, and then it shifts carry, accumulator and low half right by one place as a single unit. When the bit is zero it only shifts.

After exactly WIDTH such steps the working register holds the double-width product. The block copies it into the product output register and raises done for one clock. A start that arrives while a multiplication is running is ignored. The product output keeps its value until the next multiplication completes. The reset is synchronous and active high.

Top module: `shift_add_mult`

## Requirements
- R1: After reset, busy and done are 0 and product is all zeros.
- R2: A start sampled high while busy is 0 loads the operands, and busy is 1 from the next clock.
- R3: In each step, if the lowest multiplier bit still held is 1, the multiplicand is added to the accumulator; carry, accumulator and multiplier are then shifted right one place together. If that bit is 0, only the shift happens. For example, 11 × 13 gives 143.
- R4: The carry out of the add enters the top accumulator bit on the shift, so sums that overflow the accumulator width still give the correct product (255 × 255 = 65025 at WIDTH 8). The carry flop is zero at the start of every step.
- R5: Exactly WIDTH steps are made. If start is accepted at clock edge k, busy is high from edge k to edge k+WIDTH and done is high from edge k+WIDTH to edge k+WIDTH+1.
- R6: done is a single-cycle pulse.
- R7: When done is high, product equals mcand × mplier as unsigned numbers, taken from the operands of the accepted start. Product changes only on the edge where done rises.
- R8: A start sampled while busy is 1 has no effect: the running result and the done timing are unchanged.
- R9: A start sampled in the same cycle that done is high is accepted, and a new multiplication begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a multiplication when idle |
| mcand | input | WIDTH | Unsigned multiplicand, sampled with start |
| mplier | input | WIDTH | Unsigned multiplier, sampled with start |
| busy | output | 1 | Multiplication in progress |
| done | output | 1 | One-cycle pulse when product is updated |
| product | output | 2*WIDTH | Registered unsigned product |

## Verification
The assertions assume that reset is held high through the first clock edge, and that operands matter only in the cycle in which start is accepted. The bench meets this by keeping reset high for several cycles from time zero and by changing inputs only on the falling edge. Starts are driven in three situations: while idle, in the middle of a run, and in the cycle in which done is high. This exercises the accept, ignore and back-to-back cases that the control assertions depend on. Operand values include zero, all ones and single set bits, so that both the add-skipping path and the carry path are covered.

// File: rtl/shift_add_mult_pkg.sv
package shift_add_mult_pkg;
  // Width of an iteration counter able to count 0 .. steps-1
  function automatic int step_cnt_bits(input int steps);
    return (steps > 1) ? $clog2(steps) : 1;
  endfunction
endpackage

// File: rtl/shift_add_mult_ctrl.sv
module shift_add_mult_ctrl
  import shift_add_mult_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic load,
  output logic step,
  output logic last,
  output logic busy,
  output logic done
);
  localparam int CW = step_cnt_bits(WIDTH);
  localparam logic [CW-1:0] LAST_IDX = CW'(WIDTH - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q;

  assign load = start && !busy_q;
  assign step = busy_q;
  assign last = busy_q && (cnt_q == LAST_IDX);
  assign busy = busy_q;
  assign done = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= last;
      if (load) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (last) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else if (busy_q) begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  // R2: an accepted start leads to busy
  a_r2_start_busy: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
  // R5: the counter never passes the last step
  a_r5_count_bound: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt_q <= LAST_IDX));
  // R5: busy falls only together with the done pulse
  a_r5_done_on_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  // R6: done lasts one cycle
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R8: a start seen mid-run does not restart the count
  a_r8_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (start && busy && !last) |=> (busy && cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/shift_add_mult_datapath.sv
module shift_add_mult_datapath #(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic               step,
  input  logic [WIDTH-1:0]   mcand,
  input  logic [WIDTH-1:0]   mplier,
  output logic [2*WIDTH-1:0] next_pair
);
  localparam int PW = 2 * WIDTH;

  logic [WIDTH-1:0] m_q, a_q, q_q;
  logic             c_q;
  logic             add_en, top_in;
  logic [WIDTH:0]   sum;
  logic [WIDTH-1:0] a_nx, q_nx;

  always_comb begin
    add_en    = q_q[0];
    sum       = {1'b0, a_q} + (add_en ? {1'b0, m_q} : '0);
    top_in    = add_en ? sum[WIDTH] : c_q;
    a_nx      = {top_in, sum[WIDTH-1:1]};
    q_nx      = {sum[0], q_q[WIDTH-1:1]};
    next_pair = {a_nx, q_nx};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      m_q <= '0;
      a_q <= '0;
      q_q <= '0;
      c_q <= 1'b0;
    end else if (load) begin
      m_q <= mcand;
      a_q <= '0;
      q_q <= mplier;
      c_q <= 1'b0;
    end else if (step) begin
      a_q <= a_nx;
      q_q <= q_nx;
      c_q <= 1'b0;
    end
  end

  // R4: carry flop is clear at the start of every step
  a_r4_carry_clear: assert property (@(posedge clk) disable iff (rst)
    step |-> (c_q == 1'b0));
  // R3: the multiplicand is held for the whole run
  a_r3_mcand_hold: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> (m_q == $past(m_q)) || $past(load));
  // R3: a zero multiplier bit leaves the accumulator only shifted
  a_r3_shift_only: assert property (@(posedge clk) disable iff (rst)
    (step && !q_q[0] && !load) |=> (a_q == ($past(a_q) >> 1)));

  logic unused_pw;
  assign unused_pw = (PW == 0);
endmodule

// File: rtl/shift_add_mult.sv
module shift_add_mult #(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [WIDTH-1:0]   mcand,
  input  logic [WIDTH-1:0]   mplier,
  output logic               busy,
  output logic               done,
  output logic [2*WIDTH-1:0] product
);
  localparam int PW = 2 * WIDTH;

  logic          load, step, last;
  logic [PW-1:0] next_pair;
  logic [PW-1:0] prod_q;

  shift_add_mult_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .load  (load),
    .step  (step),
    .last  (last),
    .busy  (busy),
    .done  (done)
  );

  shift_add_mult_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .step      (step),
    .mcand     (mcand),
    .mplier    (mplier),
    .next_pair (next_pair)
  );

  always_ff @(posedge clk) begin
    if (rst)       prod_q <= '0;
    else if (last) prod_q <= next_pair;
  end

  assign product = prod_q;

  // R7: product only moves when done rises
  a_r7_product_hold: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(product));
  // R5: done never coincides with busy
  a_r5_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

// File: tb/shift_add_mult_test.sv
module shift_add_mult_test;
  localparam int W  = 8;
  localparam int PW = 2 * W;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [W-1:0]  mcand = '0;
  logic [W-1:0]  mplier = '0;
  logic          busy, done;
  logic [PW-1:0] product;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  shift_add_mult #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .start(start), .mcand(mcand),
    .mplier(mplier), .busy(busy), .done(done), .product(product)
  );

  // behavioural reference, updated on each rising edge
  logic          m_busy = 1'b0, m_done = 1'b0;
  logic [PW-1:0] m_prod = '0, m_pend = '0;
  int            m_cnt = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 1'b0; m_done = 1'b0; m_prod = '0; m_cnt = 0;
    end else begin
      m_done = 1'b0;
      if (m_busy) begin
        m_cnt = m_cnt + 1;
        if (m_cnt == W) begin
          m_busy = 1'b0; m_done = 1'b1; m_prod = m_pend;
        end
      end else if (start) begin
        m_busy = 1'b1; m_cnt = 0;
        m_pend = PW'(mcand) * PW'(mplier);
      end
    end
  end

  task automatic check(input string tag, input logic [PW-1:0] act,
                       input logic [PW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // per-clock comparison against the reference
  always @(negedge clk) begin
    if (!rst) begin
      check("R5 busy", PW'(busy), PW'(m_busy));
      check("R6 done", PW'(done), PW'(m_done));
      check("R7 product", product, m_prod);
    end
  end

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic run(input string tag, input logic [W-1:0] a,
                     input logic [W-1:0] b);
    @(negedge clk);
    mcand = a; mplier = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 busy after start", PW'(busy), PW'(1));
    wait_done();
    check(tag, product, PW'(a) * PW'(b));
  endtask

  task automatic run_all();
    logic [31:0] seed = 32'h1234_5678;
    repeat (3) @(negedge clk);
    check("R1 busy", PW'(busy), '0);
    check("R1 done", PW'(done), '0);
    check("R1 product", product, '0);
    rst = 1'b0;

    run("R3 11x13", 8'd11, 8'd13);
    check("R3 example 143", product, PW'(143));
    run("R4 carry all ones", 8'hFF, 8'hFF);
    check("R4 65025", product, PW'(65025));
    run("R7 zero mcand", 8'd0, 8'hA5);
    run("R7 zero mplier", 8'h5A, 8'd0);
    run("R3 msb only", 8'h80, 8'h02);
    run("R3 single bit mplier", 8'hFF, 8'h01);

    // R8: starts mid-run are ignored
    @(negedge clk);
    mcand = 8'd200; mplier = 8'd3; start = 1'b1;
    @(negedge clk);
    mcand = 8'd7; mplier = 8'd9;
    repeat (3) @(negedge clk);
    start = 1'b0;
    check("R8 still busy", PW'(busy), PW'(1));
    wait_done();
    check("R8 first operands kept", product, PW'(600));

    // R9: start in the done cycle is accepted
    mcand = 8'd17; mplier = 8'd19; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R9 restart busy", PW'(busy), PW'(1));
    check("R7 product held", product, PW'(600));
    wait_done();
    check("R9 restart product", product, PW'(323));

    for (int i = 0; i < 20; i++) begin
      seed = seed * 32'd1664525 + 32'd1013904223;
      run("R7 random", seed[31:24], seed[15:8]);
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule